// File: doc/BRIEF.md
# Burst-of-Four DDR SRAM Read Return Pipeline

This block models the return path of a common-I/O synchronous SRAM that always moves data in bursts of four double-rate beats. One fast clock carries two ticks per memory clock period. Ticks 0, 2, 4, ... after reset stand for rising edges of the true memory clock, and odd ticks stand for rising edges of the complementary clock. A load is taken only on an even tick while `cmd_ready` is high. A read load captures the four array words presented with it. The block then plays the four words back, lowest word first, on consecutive ticks.

In normal mode the first beat appears five ticks after the command, on a complementary-clock edge (2.5 periods). With the delay loop bypassed (`dll_off` high), the first beat appears two ticks after the command (one period). A valid flag rises one tick before the first beat. It drops one tick before the last beat of a stream, so back-to-back bursts keep it high across the join. The output side has a fixed latency and cannot be stalled. `cmd_ready` is the only back-pressure: it is low on odd ticks and on the even tick that follows an accepted load, because one burst fills two memory clock periods. `dll_off` must stay constant while any read is outstanding.

Top module: `srb4_read_pipe`

## Requirements
- R1: A load is accepted at an even tick when `ld_n` is low and `cmd_ready` is high. It is a read when `rw` is 1, and in that same tick `array_rd` is high with `array_addr` equal to `addr`.
- R2: `cmd_ready` is low on every odd tick and on the even tick two ticks after an accepted load (read or write), and high on every other even tick. A load presented while `cmd_ready` is low is ignored and produces no beats.
- R3: In normal mode (`dll_off`=0), a read accepted at tick t drives word b (`rd_words[b*DW +: DW]`, b=0..3) on `dq_o` with `dq_oe` high at tick t+5+b.
- R4: With `dll_off`=1, word b of a read accepted at tick t is driven at tick t+2+b.
- R5: `q_valid` is high at tick x exactly when beats are driven at both tick x+1 and tick x+2.
- R6: Reads accepted four ticks apart give an unbroken eight-beat stream, and `q_valid` stays high across the join.
- R7: Ticks with `ld_n` high, and write loads (`rw`=0), neither shorten nor change a burst in progress, and a write load produces no beats.
- R8: When no beat is driven, `dq_oe` is low and `dq_o` is zero.
- R9: In reset and right after it, `dq_oe`, `q_valid` and `dq_o` are zero, and the first clock edge after reset is an even tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, two ticks per memory clock period |
| rst_n | input | 1 | Active-low synchronous reset |
| dll_off | input | 1 | 1 selects the one-period latency mode |
| ld_n | input | 1 | Active-low load strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Load address |
| rd_words | input | 4*DW | Four array words for a read, word 0 in the low bits |
| cmd_ready | output | 1 | A load can be taken this tick |
| array_rd | output | 1 | Read accepted this tick |
| array_addr | output | AW | Address forwarded to the array |
| dq_o | output | DW | Data beat out |
| dq_oe | output | 1 | Output enable; a beat is being driven |
| q_valid | output | 1 | Valid indicator, one tick ahead of the data |

## Verification
The assertions check on every cycle that no load is accepted within two ticks of another, that a rise of the valid flag is followed by the start of a beat run, that every run of beats lasts at least four ticks, and that the valid flag is low in the tick before the output enable falls. Only the bench's scenarios can show the exact latency in each mode, the order of the words within a burst, that the join between back-to-back bursts has no gap, and that ignored or write loads leave the stream unchanged. Those checks compare every tick against a model that is driven by random loads in both modes.

// File: rtl/srb4_pkg.sv
package srb4_pkg;
  localparam int BEATS    = 4;
  localparam int LAT_NORM = 5;
  localparam int LAT_BYP  = 2;
  localparam int AGES     = LAT_NORM + BEATS;
  localparam int SLOTS    = 2;
  localparam int SLOT_W   = $clog2(SLOTS);
  localparam int BEAT_W   = $clog2(BEATS);

  typedef struct packed {
    logic              rd;
    logic [SLOT_W-1:0] slot;
  } age_t;
endpackage

// File: rtl/srb4_cmd.sv
module srb4_cmd
  import srb4_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_n,
  input  logic                 rw,
  output logic                 cmd_ready,
  output logic                 rd_acc,
  output logic [SLOT_W-1:0]    rd_slot,
  output age_t [AGES-1:0]      ages
);
  logic             odd_ph;
  logic [1:0]       ld_hist;
  logic             ld_acc;
  age_t [AGES-2:0]  hist;

  assign cmd_ready = rst_n && !odd_ph && !ld_hist[1];
  assign ld_acc    = !ld_n && cmd_ready;
  assign rd_acc    = ld_acc && rw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      odd_ph  <= 1'b0;
      ld_hist <= '0;
      rd_slot <= '0;
    end else begin
      odd_ph  <= ~odd_ph;
      ld_hist <= {ld_hist[0], ld_acc};
      if (rd_acc) rd_slot <= rd_slot + 1'b1;
    end
  end

  assign ages[0] = '{rd: rd_acc, slot: rd_slot};

  genvar i;
  generate
    for (i = 0; i < AGES - 1; i++) begin : g_age
      always_ff @(posedge clk) begin
        if (!rst_n) hist[i] <= '0;
        else if (i == 0) hist[i] <= ages[0];
        else hist[i] <= hist[(i == 0) ? 0 : i - 1];
      end
      assign ages[i+1] = hist[i];
    end
  endgenerate

  // R2: loads are at least two ticks apart
  a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    ld_acc |-> (!$past(ld_acc) && !$past(ld_acc, 2)));
endmodule

// File: rtl/srb4_store.sv
module srb4_store
  import srb4_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic [SLOT_W-1:0]     wr_slot,
  input  logic [BEATS*DW-1:0]   wr_words,
  input  logic [SLOT_W-1:0]     sel_slot,
  input  logic [BEAT_W-1:0]     sel_beat,
  output logic [DW-1:0]         sel_word
);
  logic [BEATS*DW-1:0] mem [SLOTS];

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk) begin
        if (wr_en && wr_slot == SLOT_W'(s)) mem[s] <= wr_words;
      end
    end
  endgenerate

  assign sel_word = mem[sel_slot][sel_beat*DW +: DW];
endmodule

// File: rtl/srb4_beat.sv
module srb4_beat
  import srb4_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dll_off,
  input  age_t [AGES-1:0]    ages,
  input  logic [DW-1:0]      sel_word,
  output logic [SLOT_W-1:0]  sel_slot,
  output logic [BEAT_W-1:0]  sel_beat,
  output logic [DW-1:0]      dq_o,
  output logic               dq_oe,
  output logic               q_valid
);
  logic [2:0] here;
  int         lat;

  always_comb begin
    lat      = dll_off ? LAT_BYP : LAT_NORM;
    here     = '0;
    sel_slot = '0;
    sel_beat = '0;
    for (int d = 0; d < 3; d++) begin
      for (int k = 0; k < AGES; k++) begin
        if (ages[k].rd && k >= lat - d && k <= lat + BEATS - 1 - d)
          here[d] = 1'b1;
      end
    end
    for (int k = 0; k < AGES; k++) begin
      if (ages[k].rd && k >= lat && k <= lat + BEATS - 1) begin
        sel_slot = ages[k].slot;
        sel_beat = BEAT_W'(k - lat);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dq_oe   <= 1'b0;
      q_valid <= 1'b0;
      dq_o    <= '0;
    end else begin
      dq_oe   <= here[0];
      q_valid <= here[1] && here[2];
      dq_o    <= here[0] ? sel_word : '0;
    end
  end

  // R5: valid rising announces the first beat one tick later
  a_r5_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_valid) |=> $rose(dq_oe));
  // R5: valid is already low in the tick before the last beat ends
  a_r5_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> !$past(q_valid));
  // R3/R4: a burst never shrinks below four beats
  a_r3_four: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |=> dq_oe ##1 dq_oe ##1 dq_oe);
endmodule

// File: rtl/srb4_read_pipe.sv
module srb4_read_pipe
  import srb4_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dll_off,
  input  logic                 ld_n,
  input  logic                 rw,
  input  logic [AW-1:0]        addr,
  input  logic [BEATS*DW-1:0]  rd_words,
  output logic                 cmd_ready,
  output logic                 array_rd,
  output logic [AW-1:0]        array_addr,
  output logic [DW-1:0]        dq_o,
  output logic                 dq_oe,
  output logic                 q_valid
);
  age_t [AGES-1:0]    ages;
  logic [SLOT_W-1:0]  wr_slot;
  logic [SLOT_W-1:0]  sel_slot;
  logic [BEAT_W-1:0]  sel_beat;
  logic [DW-1:0]      sel_word;

  assign array_addr = addr;

  srb4_cmd u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_n      (ld_n),
    .rw        (rw),
    .cmd_ready (cmd_ready),
    .rd_acc    (array_rd),
    .rd_slot   (wr_slot),
    .ages      (ages)
  );

  srb4_store #(.DW(DW)) u_store (
    .clk      (clk),
    .wr_en    (array_rd),
    .wr_slot  (wr_slot),
    .wr_words (rd_words),
    .sel_slot (sel_slot),
    .sel_beat (sel_beat),
    .sel_word (sel_word)
  );

  srb4_beat #(.DW(DW)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .dll_off  (dll_off),
    .ages     (ages),
    .sel_word (sel_word),
    .sel_slot (sel_slot),
    .sel_beat (sel_beat),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe),
    .q_valid  (q_valid)
  );
endmodule

// File: tb/sim_srb4_read_pipe.sv
`timescale 1ns/1ps
module sim_srb4_read_pipe;
  localparam int DW = 16;
  localparam int AW = 20;
  localparam int NT = 4096;

  logic clk = 0;
  logic rst_n = 0;
  logic dll_off = 0;
  logic ld_n = 1;
  logic rw = 0;
  logic [AW-1:0] addr = '0;
  logic [4*DW-1:0] rd_words = '0;
  logic cmd_ready, array_rd, dq_oe, q_valid;
  logic [AW-1:0] array_addr;
  logic [DW-1:0] dq_o;

  always #2.5 clk = ~clk;

  srb4_read_pipe #(.DW(DW), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .dll_off(dll_off), .ld_n(ld_n), .rw(rw),
    .addr(addr), .rd_words(rd_words), .cmd_ready(cmd_ready),
    .array_rd(array_rd), .array_addr(array_addr), .dq_o(dq_o),
    .dq_oe(dq_oe), .q_valid(q_valid)
  );

  int vectors = 0;
  int miscompares = 0;
  int tk = 0;
  int last_ld = -100;
  string cur_tag = "R3";
  logic e_oe [NT];
  logic [DW-1:0] e_dq [NT];

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s tick %0d got %0h expected %0h", tag, tk, got, exp);
    end
  endtask

  function automatic int lat_of(input logic off);
    return off ? 2 : 5;
  endfunction

  task automatic do_tick(input logic ldn, input logic rwv, input logic [AW-1:0] a,
                         input logic [4*DW-1:0] w);
    logic rdy, acc, rd;
    @(negedge clk);
    ld_n = ldn; rw = rwv; addr = a; rd_words = w;
    #1;
    rdy = (tk % 2 == 0) && (last_ld != tk - 2);
    chk("R2", 64'(cmd_ready), 64'(rdy));
    acc = rdy && !ldn;
    rd  = acc && rwv;
    chk("R1", 64'(array_rd), 64'(rd));
    if (rd) chk("R1", 64'(array_addr), 64'(a));
    if (acc) last_ld = tk;
    if (rd) begin
      for (int b = 0; b < 4; b++) begin
        e_oe[tk + lat_of(dll_off) + b] = 1'b1;
        e_dq[tk + lat_of(dll_off) + b] = w[b*DW +: DW];
      end
    end
    @(posedge clk);
    #1;
    chk(cur_tag, 64'(dq_oe), 64'(e_oe[tk]));
    if (e_oe[tk]) chk(cur_tag, 64'(dq_o), 64'(e_dq[tk]));
    else chk("R8", 64'(dq_o), 64'd0);
    chk("R5", 64'(q_valid), 64'(e_oe[tk+1] && e_oe[tk+2]));
    tk++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) do_tick(1'b1, 1'b0, '0, '0);
  endtask

  function automatic logic [4*DW-1:0] rnd_words();
    return {$urandom, $urandom};
  endfunction

  task automatic rnd_run(input int n);
    for (int i = 0; i < n; i++)
      do_tick(($urandom % 2) == 0, ($urandom % 3) != 0, AW'($urandom), rnd_words());
  endtask

  task automatic b2b();
    do_tick(1'b0, 1'b1, 20'h00011, 64'h1111_2222_3333_4444);
    idle(3);
    do_tick(1'b0, 1'b1, 20'h00022, 64'h5555_6666_7777_8888);
    idle(12);
  endtask

  initial begin
    for (int i = 0; i < NT; i++) begin e_oe[i] = 1'b0; e_dq[i] = '0; end
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1;
    chk("R9", 64'(dq_oe), 64'd0);
    chk("R9", 64'(q_valid), 64'd0);
    chk("R9", 64'(dq_o), 64'd0);
    rst_n = 1;
    #0.5;
    chk("R9", 64'(cmd_ready), 64'd1);

    cur_tag = "R3";
    do_tick(1'b0, 1'b1, 20'h00abc, 64'hdddd_cccc_bbbb_aaaa);
    idle(12);

    cur_tag = "R6";
    b2b();

    cur_tag = "R7";
    do_tick(1'b0, 1'b1, 20'h00100, 64'h0404_0303_0202_0101);
    idle(3);
    do_tick(1'b0, 1'b0, 20'h00200, 64'hffff_ffff_ffff_ffff);
    idle(3);
    do_tick(1'b0, 1'b0, 20'h00300, 64'heeee_eeee_eeee_eeee);
    idle(12);

    cur_tag = "R2";
    do_tick(1'b0, 1'b1, 20'h00400, 64'h1234_5678_9abc_def0);
    do_tick(1'b0, 1'b1, 20'h00401, 64'hbad0_bad1_bad2_bad3);
    do_tick(1'b0, 1'b1, 20'h00402, 64'hbad4_bad5_bad6_bad7);
    do_tick(1'b0, 1'b1, 20'h00403, 64'hbad8_bad9_bada_badb);
    idle(12);

    cur_tag = "R3";
    rnd_run(600);
    idle(12);

    dll_off = 1;
    cur_tag = "R4";
    do_tick(1'b0, 1'b1, 20'h00777, 64'h4444_3333_2222_1111);
    idle(8);
    cur_tag = "R6";
    b2b();
    cur_tag = "R4";
    rnd_run(600);
    idle(12);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #200000;
    miscompares++;
    vectors++;
    $display("FAIL watchdog tick %0d got hung expected done", tk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule